// File: doc/BRIEF.md
# Trace Cache Path-Matched Fetch

This block is a small direct-mapped trace cache that sits beside the fetch stage. Each entry holds a run of up to sixteen instructions spanning several basic blocks. The entry is tagged by the address where the run starts. It also records up to three conditional branches inside the run: the direction each one took when the run was built, its slot position, its fall-through address and its target address. A fill unit installs entries through a write port. Installing at an index overwrites whatever was there.

On a fetch request the block reads the entry selected by the low bits of the fetch address. It compares the stored start address, then compares the stored branch directions with the predictor's directions. A full path match supplies the whole run and the address that follows it. With partial supply enabled, a path that diverges at some branch supplies the slots up to and including that branch, and steers the next fetch along the predicted direction of that branch. Any other case reports a miss, and fetch falls back to the ordinary instruction path.

Later, the back end reports the resolved direction of a supplied branch. If that direction differs from the direction that was followed, the block emits a one-cycle flush. The flush names the first slot to discard and the address where fetch must restart.

Top module: `trace_cache_fetch`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses; `tc_vld` and `flush_vld` are low while reset is held.
- R2: A fetch sampled on one rising edge produces its response (`tc_vld` high for one cycle) after the second rising edge. Nothing is shown after the first edge.
- R3: When the indexed entry is invalid or its start address differs from `fetch_addr`, the response has `tc_miss`=1, `tc_hit`=0, `tc_mask`=0 and `tc_next`=0.
- R4: When the start address matches and `fetch_pred[j]` equals the stored direction for every branch j below the stored branch count, the response is a hit with `tc_part`=0. The mask has bits 0..len-1 set, `tc_next` is the stored end address, and slot i of `tc_insn` (bits 16i+15..16i) is the stored instruction. Direction bit j is 1 for taken.
- R5: With `part_en`=1, let k be the lowest branch whose predicted direction differs from the stored one. The response is then a hit with `tc_part`=1 and mask bits 0..pos[k] set. `tc_next` is the target of branch k if `fetch_pred[k]`=1, and its fall-through otherwise.
- R6: With `part_en`=0, a diverging path gives a miss.
- R7: Prediction bits at or above the stored branch count have no effect on the response.
- R8: A write stores the entry at index `wr_addr[IDX_W-1:0]` and replaces the old one; the old start address then misses.
- R9: After a hit that supplied n branches (all of them on a full match, k+1 on a partial one), a resolve with `rs_br` < n and `rs_taken` different from the followed direction `fetch_pred[rs_br]` raises `flush_vld` for exactly one cycle after the next edge. With it, `flush_slot` = pos[rs_br]+1, and `flush_addr` is the target if `rs_taken`=1, else the fall-through.
- R10: A resolve that agrees with the followed direction, names a branch not supplied, or follows a miss causes no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Lookup request |
| fetch_addr | input | 16 | Start address to look up |
| fetch_pred | input | 3 | Predicted direction per branch, 1 = taken |
| part_en | input | 1 | Allow prefix supply on a diverging path |
| wr_en | input | 1 | Install an entry |
| wr_addr | input | 16 | Start address of the installed run |
| wr_len | input | 5 | Number of valid slots, 1..16 |
| wr_nbr | input | 2 | Number of branches in the run, 0..3 |
| wr_dir | input | 3 | Stored direction per branch |
| wr_pos | input | 12 | Slot position per branch, 4 bits each |
| wr_fall | input | 48 | Fall-through address per branch |
| wr_tgt | input | 48 | Target address per branch |
| wr_end | input | 16 | Address following the complete run |
| wr_insn | input | 256 | Sixteen 16-bit instruction slots |
| rs_valid | input | 1 | Resolved branch report |
| rs_br | input | 2 | Branch number within the supplied run |
| rs_taken | input | 1 | Resolved direction |
| tc_vld | output | 1 | Response present |
| tc_hit | output | 1 | Run supplied |
| tc_miss | output | 1 | No usable run |
| tc_part | output | 1 | Only a prefix supplied |
| tc_mask | output | 16 | Valid slot mask |
| tc_insn | output | 256 | Supplied slots |
| tc_next | output | 16 | Next fetch address |
| flush_vld | output | 1 | Discard part of the supplied run |
| flush_slot | output | 5 | First slot to discard |
| flush_addr | output | 16 | Corrected fetch address |

## Verification
The latency property assumes that `fetch_valid` is low while reset is asserted. The bench holds it low until reset is released. The one-cycle flush property assumes that resolves never come on back-to-back cycles. Each resolve in the stimulus is followed by at least one idle cycle, and each one refers to the most recent response. Entries are installed with branch positions that rise and lie below the run length, which the mask-shape property relies on.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int ADDR_W = 16;
  localparam int INSN_W = 16;
  localparam int SLOTS  = 16;
  localparam int MAX_BR = 3;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int CNT_W  = $clog2(SLOTS + 1);
  localparam int BRC_W  = $clog2(MAX_BR + 1);

  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    addr_t                          tag;
    logic [CNT_W-1:0]               len;
    logic [BRC_W-1:0]               nbr;
    logic [MAX_BR-1:0]              dir;
    logic [MAX_BR-1:0][SLOT_W-1:0]  pos;
    logic [MAX_BR-1:0][ADDR_W-1:0]  fall;
    logic [MAX_BR-1:0][ADDR_W-1:0]  tgt;
    addr_t                          end_a;
    logic [SLOTS-1:0][INSN_W-1:0]   insn;
  } entry_t;
endpackage

// File: rtl/tc_store.sv
module tc_store
  import tc_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  entry_t           wdata,
  input  logic [IDX_W-1:0] ridx,
  output entry_t           rd_ent,
  output logic             rd_vld
);
  localparam int DEPTH = 1 << IDX_W;

  entry_t           mem [DEPTH];
  logic [DEPTH-1:0] vbits;

  // Data array: no reset, read-first, so it maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    rd_ent <= mem[ridx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vbits  <= '0;
      rd_vld <= 1'b0;
    end else begin
      if (we) vbits[widx] <= 1'b1;
      rd_vld <= vbits[ridx];
    end
  end
endmodule

// File: rtl/tc_match.sv
module tc_match
  import tc_pkg::*;
(
  input  entry_t            ent,
  input  logic              tag_ok,
  input  logic [MAX_BR-1:0] pred,
  input  logic              part_en,
  output logic              hit,
  output logic              part,
  output logic [SLOTS-1:0]  mask,
  output addr_t             next_a,
  output logic [BRC_W-1:0]  nsup
);
  logic                     found;
  logic [BRC_W-1:0]         k;

  always_comb begin
    found = 1'b0;
    k     = '0;
    for (int j = 0; j < MAX_BR; j++) begin
      if (!found && (j < int'(ent.nbr)) && (ent.dir[j] != pred[j])) begin
        found = 1'b1;
        k     = BRC_W'(j);
      end
    end
    hit  = tag_ok && (!found || part_en);
    part = found;
    for (int i = 0; i < SLOTS; i++) begin
      if (found) mask[i] = (i <= int'(ent.pos[k]));
      else       mask[i] = (i < int'(ent.len));
    end
    if (found) begin
      next_a = pred[k] ? ent.tgt[k] : ent.fall[k];
      nsup   = k + 1'b1;
    end else begin
      next_a = ent.end_a;
      nsup   = ent.nbr;
    end
  end
endmodule

// File: rtl/tc_verify.sv
module tc_verify
  import tc_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           upd,
  input  logic                           hit,
  input  logic [MAX_BR-1:0]              pred,
  input  logic [BRC_W-1:0]               nsup,
  input  logic [MAX_BR-1:0][SLOT_W-1:0]  pos,
  input  logic [MAX_BR-1:0][ADDR_W-1:0]  fall,
  input  logic [MAX_BR-1:0][ADDR_W-1:0]  tgt,
  input  logic                           rs_valid,
  input  logic [BRC_W-1:0]               rs_br,
  input  logic                           rs_taken,
  output logic                           flush_vld,
  output logic [CNT_W-1:0]               flush_slot,
  output addr_t                          flush_addr
);
  logic [MAX_BR-1:0]              sup_pred;
  logic [BRC_W-1:0]               sup_n;
  logic [MAX_BR-1:0][SLOT_W-1:0]  sup_pos;
  logic [MAX_BR-1:0][ADDR_W-1:0]  sup_fall;
  logic [MAX_BR-1:0][ADDR_W-1:0]  sup_tgt;
  logic                           wrong;

  assign wrong = rs_valid && (rs_br < sup_n) && (rs_taken != sup_pred[rs_br]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sup_n      <= '0;
      flush_vld  <= 1'b0;
      flush_slot <= '0;
      flush_addr <= '0;
    end else begin
      if (upd) sup_n <= hit ? nsup : '0;
      flush_vld <= wrong;
      if (wrong) begin
        flush_slot <= CNT_W'(sup_pos[rs_br]) + 1'b1;
        flush_addr <= rs_taken ? sup_tgt[rs_br] : sup_fall[rs_br];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (upd) begin
      sup_pred <= pred;
      sup_pos  <= pos;
      sup_fall <= fall;
      sup_tgt  <= tgt;
    end
  end
endmodule

// File: rtl/trace_cache_fetch.sv
module trace_cache_fetch
  import tc_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        fetch_valid,
  input  logic [ADDR_W-1:0]           fetch_addr,
  input  logic [MAX_BR-1:0]           fetch_pred,
  input  logic                        part_en,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [CNT_W-1:0]            wr_len,
  input  logic [BRC_W-1:0]            wr_nbr,
  input  logic [MAX_BR-1:0]           wr_dir,
  input  logic [MAX_BR*SLOT_W-1:0]    wr_pos,
  input  logic [MAX_BR*ADDR_W-1:0]    wr_fall,
  input  logic [MAX_BR*ADDR_W-1:0]    wr_tgt,
  input  logic [ADDR_W-1:0]           wr_end,
  input  logic [SLOTS*INSN_W-1:0]     wr_insn,
  input  logic                        rs_valid,
  input  logic [BRC_W-1:0]            rs_br,
  input  logic                        rs_taken,
  output logic                        tc_vld,
  output logic                        tc_hit,
  output logic                        tc_miss,
  output logic                        tc_part,
  output logic [SLOTS-1:0]            tc_mask,
  output logic [SLOTS*INSN_W-1:0]     tc_insn,
  output logic [ADDR_W-1:0]           tc_next,
  output logic                        flush_vld,
  output logic [CNT_W-1:0]            flush_slot,
  output logic [ADDR_W-1:0]           flush_addr
);
  entry_t             wr_ent, rd_ent;
  logic               rd_vld;
  logic               s1_v, s1_pe;
  addr_t              s1_addr;
  logic [MAX_BR-1:0]  s1_pred;
  logic               m_hit, m_part;
  logic [SLOTS-1:0]   m_mask;
  addr_t              m_next;
  logic [BRC_W-1:0]   m_nsup;
  logic               take;

  assign wr_ent.tag   = wr_addr;
  assign wr_ent.len   = wr_len;
  assign wr_ent.nbr   = wr_nbr;
  assign wr_ent.dir   = wr_dir;
  assign wr_ent.pos   = wr_pos;
  assign wr_ent.fall  = wr_fall;
  assign wr_ent.tgt   = wr_tgt;
  assign wr_ent.end_a = wr_end;
  assign wr_ent.insn  = wr_insn;

  tc_store #(.IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .we(wr_en), .widx(wr_addr[IDX_W-1:0]),
    .wdata(wr_ent), .ridx(fetch_addr[IDX_W-1:0]),
    .rd_ent(rd_ent), .rd_vld(rd_vld)
  );

  // Stage 1: request travels alongside the RAM read
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_addr <= '0;
      s1_pred <= '0;
      s1_pe   <= 1'b0;
    end else begin
      s1_v    <= fetch_valid;
      s1_addr <= fetch_addr;
      s1_pred <= fetch_pred;
      s1_pe   <= part_en;
    end
  end

  tc_match u_match (
    .ent(rd_ent), .tag_ok(rd_vld && (rd_ent.tag == s1_addr)),
    .pred(s1_pred), .part_en(s1_pe),
    .hit(m_hit), .part(m_part), .mask(m_mask), .next_a(m_next), .nsup(m_nsup)
  );

  assign take = s1_v && m_hit;

  // Stage 2: registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      tc_vld  <= 1'b0;
      tc_hit  <= 1'b0;
      tc_miss <= 1'b0;
      tc_part <= 1'b0;
      tc_mask <= '0;
      tc_insn <= '0;
      tc_next <= '0;
    end else begin
      tc_vld  <= s1_v;
      tc_hit  <= take;
      tc_miss <= s1_v && !m_hit;
      tc_part <= take && m_part;
      tc_mask <= take ? m_mask : '0;
      tc_insn <= take ? rd_ent.insn : '0;
      tc_next <= take ? m_next : '0;
    end
  end

  tc_verify u_verify (
    .clk(clk), .rst(rst), .upd(s1_v), .hit(m_hit), .pred(s1_pred),
    .nsup(m_nsup), .pos(rd_ent.pos), .fall(rd_ent.fall), .tgt(rd_ent.tgt),
    .rs_valid(rs_valid), .rs_br(rs_br), .rs_taken(rs_taken),
    .flush_vld(flush_vld), .flush_slot(flush_slot), .flush_addr(flush_addr)
  );
endmodule

// File: rtl/tc_checker.sv
module tc_checker
  import tc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              fetch_valid,
  input logic              tc_vld,
  input logic              tc_hit,
  input logic              tc_miss,
  input logic              tc_part,
  input logic [SLOTS-1:0]  tc_mask,
  input logic              flush_vld,
  input logic [CNT_W-1:0]  flush_slot
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!tc_vld && !flush_vld));

  p_resp_latency_r2: assert property (@(posedge clk) disable iff (rst)
    tc_vld == $past(fetch_valid, 2));

  p_hit_xor_miss_r3: assert property (@(posedge clk) disable iff (rst)
    tc_vld |-> (tc_hit ^ tc_miss));

  p_idle_no_result_r3: assert property (@(posedge clk) disable iff (rst)
    !tc_vld |-> (!tc_hit && !tc_miss));

  p_miss_empty_mask_r3: assert property (@(posedge clk) disable iff (rst)
    tc_miss |-> (tc_mask == '0));

  p_mask_prefix_r4: assert property (@(posedge clk) disable iff (rst)
    tc_hit |-> (tc_mask[0] && ((tc_mask & (tc_mask + 1'b1)) == '0)));

  p_part_needs_hit_r5: assert property (@(posedge clk) disable iff (rst)
    tc_part |-> tc_hit);

  p_flush_single_r9: assert property (@(posedge clk) disable iff (rst)
    flush_vld |=> !flush_vld);

  p_flush_slot_range_r9: assert property (@(posedge clk) disable iff (rst)
    flush_vld |-> ((flush_slot != '0) && (int'(flush_slot) <= SLOTS)));
endmodule

bind trace_cache_fetch tc_checker u_tc_checker (
  .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .tc_vld(tc_vld),
  .tc_hit(tc_hit), .tc_miss(tc_miss), .tc_part(tc_part), .tc_mask(tc_mask),
  .flush_vld(flush_vld), .flush_slot(flush_slot)
);

// File: tb/test_trace_cache_fetch.sv
`timescale 1ns/1ps
module test_trace_cache_fetch;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         fetch_valid = 0, part_en = 0, wr_en = 0, rs_valid = 0, rs_taken = 0;
  logic [15:0]  fetch_addr = 0, wr_addr = 0, wr_end = 0;
  logic [2:0]   fetch_pred = 0, wr_dir = 0;
  logic [4:0]   wr_len = 0;
  logic [1:0]   wr_nbr = 0, rs_br = 0;
  logic [11:0]  wr_pos = 0;
  logic [47:0]  wr_fall = 0, wr_tgt = 0;
  logic [255:0] wr_insn = 0;
  logic         tc_vld, tc_hit, tc_miss, tc_part, flush_vld;
  logic [15:0]  tc_mask, tc_next, flush_addr;
  logic [255:0] tc_insn;
  logic [4:0]   flush_slot;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  trace_cache_fetch i_trace_cache_fetch (.*);

  // {addr16, pred3, part_en, hit, part, mask16, next16}
  localparam int NV = 10;
  localparam logic [53:0] VEC [NV] = '{
    {16'h0010, 3'b101, 1'b1, 1'b1, 1'b0, 16'h0FFF, 16'h0300}, // R4 full
    {16'h0010, 3'b100, 1'b1, 1'b1, 1'b1, 16'h0007, 16'h0100}, // R5 k=0
    {16'h0010, 3'b111, 1'b1, 1'b1, 1'b1, 16'h007F, 16'h0201}, // R5 k=1
    {16'h0010, 3'b001, 1'b1, 1'b1, 1'b1, 16'h07FF, 16'h0102}, // R5 k=2
    {16'h0010, 3'b100, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R6
    {16'h0021, 3'b110, 1'b1, 1'b1, 1'b0, 16'h001F, 16'h0310}, // R7
    {16'h0021, 3'b001, 1'b1, 1'b1, 1'b1, 16'h000F, 16'h0210}, // R5
    {16'h0032, 3'b111, 1'b0, 1'b1, 1'b0, 16'hFFFF, 16'h0320}, // R4/R7 no branches
    {16'h0018, 3'b000, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R3 tag differs
    {16'h0044, 3'b000, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0000}  // R3 empty
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic install(input logic [15:0] a, input int e, input int len, input int nbr,
                         input logic [2:0] dir, input logic [11:0] pos);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_len = 5'(len); wr_nbr = 2'(nbr); wr_dir = dir; wr_pos = pos;
    wr_end = 16'h0300 + 16'(16 * e);
    for (int j = 0; j < 3; j++) begin
      wr_fall[j*16 +: 16] = 16'h0100 + 16'(16 * e + j);
      wr_tgt[j*16 +: 16]  = 16'h0200 + 16'(16 * e + j);
    end
    for (int i = 0; i < 16; i++) wr_insn[i*16 +: 16] = 16'hA000 | 16'(e << 8) | 16'(i);
    @(negedge clk);
    wr_en = 0;
  endtask

  // Ends at the negedge after the response edge; outputs are stable there
  task automatic lookup(input logic [15:0] a, input logic [2:0] p, input logic pe);
    @(negedge clk);
    fetch_valid = 1; fetch_addr = a; fetch_pred = p; part_en = pe;
    @(negedge clk);
    fetch_valid = 0;
    check("R2 no response after one edge", 32'(tc_vld), 32'd0);
    @(negedge clk);
    check("R2 response after two edges", 32'(tc_vld), 32'd1);
  endtask

  task automatic resolve(input logic [1:0] br, input logic tk, input logic exp_f,
                         input logic [4:0] exp_slot, input logic [15:0] exp_addr, input string req);
    rs_valid = 1; rs_br = br; rs_taken = tk;
    @(negedge clk);
    rs_valid = 0;
    check(req, 32'(flush_vld), 32'(exp_f));
    if (exp_f) begin
      check({req, " slot"}, 32'(flush_slot), 32'(exp_slot));
      check({req, " addr"}, 32'(flush_addr), 32'(exp_addr));
    end
    @(negedge clk);
    check({req, " one cycle"}, 32'(flush_vld), 32'd0);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    check("R1 tc_vld in reset", 32'(tc_vld), 32'd0);
    check("R1 flush_vld in reset", 32'(flush_vld), 32'd0);
    rst = 0;
    lookup(16'h0010, 3'b101, 1'b1);
    check("R1 miss after reset", 32'(tc_miss), 32'd1);
    check("R1 no hit after reset", 32'(tc_hit), 32'd0);

    install(16'h0010, 0, 12, 3, 3'b101, {4'd10, 4'd6, 4'd2});
    install(16'h0021, 1, 5, 1, 3'b000, {4'd0, 4'd0, 4'd3});
    install(16'h0032, 2, 16, 0, 3'b000, 12'h000);

    for (int v = 0; v < NV; v++) begin
      logic [53:0] t;
      t = VEC[v];
      lookup(t[53:38], t[37:35], t[34]);
      check($sformatf("R3-R7 vec%0d hit", v), 32'(tc_hit), 32'(t[33]));
      check($sformatf("R3 vec%0d miss", v), 32'(tc_miss), 32'(!t[33]));
      check($sformatf("R5 vec%0d part", v), 32'(tc_part), 32'(t[32]));
      check($sformatf("R4 vec%0d mask", v), 32'(tc_mask), 32'(t[31:16]));
      check($sformatf("R4 vec%0d next", v), 32'(tc_next), 32'(t[15:0]));
      if (t[33])
        for (int i = 0; i < 16; i++)
          if (t[16 + i])
            check($sformatf("R4 vec%0d slot%0d", v, i), 32'(tc_insn[i*16 +: 16]),
                  32'(16'hA000 | 16'(int'(t[40:38]) << 8) | 16'(i)));
    end

    // Flush after a full hit: followed directions 1,0,1
    lookup(16'h0010, 3'b101, 1'b1);
    resolve(2'd1, 1'b1, 1'b1, 5'd7, 16'h0201, "R9 full-hit wrong br1");
    resolve(2'd0, 1'b1, 1'b0, 5'd0, 16'h0000, "R10 agreeing resolve");
    // Flush after a prefix: only branch 0 supplied, followed not-taken
    lookup(16'h0010, 3'b100, 1'b1);
    resolve(2'd0, 1'b1, 1'b1, 5'd3, 16'h0200, "R9 prefix wrong br0");
    resolve(2'd2, 1'b0, 1'b0, 5'd0, 16'h0000, "R10 branch not supplied");
    lookup(16'h0044, 3'b000, 1'b1);
    resolve(2'd0, 1'b1, 1'b0, 5'd0, 16'h0000, "R10 after miss");

    // Replacement at index 0
    install(16'h0018, 5, 4, 0, 3'b000, 12'h000);
    lookup(16'h0018, 3'b000, 1'b1);
    check("R8 new entry hit", 32'(tc_hit), 32'd1);
    check("R8 new entry mask", 32'(tc_mask), 32'h000F);
    check("R8 new entry next", 32'(tc_next), 32'h0350);
    lookup(16'h0010, 3'b101, 1'b1);
    check("R8 old entry replaced", 32'(tc_miss), 32'd1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule